// File: doc/BRIEF.md
# Threshold Window Interrupt with Consecutive-Sample Filter

This block watches a stream of 16-bit light-channel conversion results and raises an interrupt when the readings leave a programmable window. Each result arrives with a one-cycle valid strobe. It is compared against a low and a high limit.

A 4-bit filter code sets how many out-of-window results in a row are needed before the interrupt is raised. The code scale is linear for small values and then moves in steps of five. One code value makes every conversion raise the interrupt, whatever its value.

Once raised, a sticky status bit holds until software sends a one-cycle clear pulse. An enable mask gates only the active-low pin. The status bit keeps working while the pin is masked.

Top module: `wpi_irq`

## Requirements
- R1: With lowThr <= highThr, a valid sample counts as out of window when it is strictly less than lowThr or strictly greater than highThr. Values equal to either limit are inside the window.
- R2: With lowThr > highThr, the high comparison is dropped. A valid sample is out of window only when it is strictly less than lowThr.
- R3: With persistCode = 0, every valid sample sets irqStatus on the clock edge that takes it, whether it is inside or outside the window.
- R4: With persistCode = 1, 2 or 3, irqStatus is set on the edge that takes the N-th consecutive out-of-window valid sample, where N equals the code, and not before.
- R5: With persistCode = 4 to 15, the required run length is 5*(code-3), so 4 gives 5 and 15 gives 60.
- R6: A valid in-window sample restarts the run from zero. Cycles without sampleValid neither extend nor break a run. The run counter saturates instead of wrapping.
- R7: Once set, irqStatus stays at 1 until an edge where irqClear is 1. It reads 0 after that edge, unless R8 applies.
- R8: When irqClear and a sample that completes the required run (or any valid sample under code 0) arrive on the same edge, irqStatus is 1 after that edge.
- R9: irqClear also resets the run count to zero, so a full new run is needed after a clear.
- R10: irqPinN is 0 exactly when irqStatus is 1 and irqEnable is 1, and 1 otherwise. irqEnable has no effect on irqStatus.
- R11: After reset, irqStatus is 0, irqPinN is 1 and the run count is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| sample | input | 16 | Conversion result |
| sampleValid | input | 1 | One-cycle strobe marking a new result |
| lowThr | input | 16 | Lower window limit |
| highThr | input | 16 | Upper window limit |
| persistCode | input | 4 | Consecutive-sample filter code |
| irqEnable | input | 1 | Mask for the pin output |
| irqClear | input | 1 | One-cycle interrupt clear |
| irqStatus | output | 1 | Sticky interrupt status |
| irqPinN | output | 1 | Interrupt pin level, active low |

## Verification
The run counter is not visible at the ports. A wrong count shows up only as irqStatus rising one or more samples early or late, on the edge of the sample that should have completed the run. Each filter code is therefore swept with runs one short of the target and exactly at it, with and without an in-window break. A stale count after a clear appears as an early interrupt on the first post-clear run. Comparator faults appear on the edge of the offending single sample, and a sweep of small limits and values covers both limit orderings.

// File: rtl/wpi_pkg.sv
package wpi_pkg;
  // strobes from control to the run counter
  typedef struct packed {
    logic step;   // extend the run by one
    logic clear;  // restart the run at zero
  } cntCmd_t;
endpackage

// File: rtl/wpi_datapath.sv
module wpi_datapath
  import wpi_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int CNT_W  = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [DATA_W-1:0] sample,
  input  logic [DATA_W-1:0] lowThr,
  input  logic [DATA_W-1:0] highThr,
  input  cntCmd_t           cmd,
  output logic              outOfRange,
  output logic [CNT_W-1:0]  runNext
);
  logic [CNT_W-1:0] runCnt;
  logic belowLow, aboveHigh, highLive;

  // low compare always applies; high compare only with a sane window
  assign belowLow   = sample < lowThr;
  assign aboveHigh  = sample > highThr;
  assign highLive   = lowThr <= highThr;
  assign outOfRange = belowLow | (highLive & aboveHigh);

  // saturating successor of the run count
  assign runNext = (runCnt == {CNT_W{1'b1}}) ? runCnt : runCnt + 1'b1;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          runCnt <= '0;
    else if (cmd.clear) runCnt <= '0;
    else if (cmd.step)  runCnt <= runNext;
  end
endmodule

// File: rtl/wpi_control.sv
module wpi_control
  import wpi_pkg::*;
#(
  parameter int CODE_W    = 4,
  parameter int CNT_W     = 6,
  parameter int LIN_CODES = 3,
  parameter int STEP      = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sampleValid,
  input  logic              irqClear,
  input  logic [CODE_W-1:0] persistCode,
  input  logic              outOfRange,
  input  logic [CNT_W-1:0]  runNext,
  output cntCmd_t           cmd,
  output logic              irqStatus
);
  logic [CNT_W-1:0] required;
  logic everyCycle, fire;

  // piecewise code scale: linear up to LIN_CODES, then STEP per code
  always_comb begin
    if (int'(persistCode) <= LIN_CODES)
      required = CNT_W'(int'(persistCode));
    else
      required = CNT_W'(STEP * (int'(persistCode) - LIN_CODES));
  end

  assign everyCycle = (persistCode == '0);
  assign fire = sampleValid & (everyCycle | (outOfRange & (runNext >= required)));

  assign cmd.step  = sampleValid & outOfRange;
  assign cmd.clear = irqClear | (sampleValid & ~outOfRange);

  // new event beats a simultaneous clear
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)         irqStatus <= 1'b0;
    else if (fire)     irqStatus <= 1'b1;
    else if (irqClear) irqStatus <= 1'b0;
  end
endmodule

// File: rtl/wpi_irq.sv
module wpi_irq
  import wpi_pkg::*;
#(
  parameter int DATA_W    = 16,
  parameter int CODE_W    = 4,
  parameter int LIN_CODES = 3,
  parameter int STEP      = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [DATA_W-1:0] sample,
  input  logic              sampleValid,
  input  logic [DATA_W-1:0] lowThr,
  input  logic [DATA_W-1:0] highThr,
  input  logic [CODE_W-1:0] persistCode,
  input  logic              irqEnable,
  input  logic              irqClear,
  output logic              irqStatus,
  output logic              irqPinN
);
  localparam int MAX_REQ = STEP * ((1 << CODE_W) - 1 - LIN_CODES);
  localparam int CNT_W   = $clog2(MAX_REQ + 1);

  cntCmd_t          cmd;
  logic             outOfRange;
  logic [CNT_W-1:0] runNext;

  wpi_datapath #(.DATA_W(DATA_W), .CNT_W(CNT_W)) dp (
    .clk(clk), .rstN(rstN), .sample(sample), .lowThr(lowThr),
    .highThr(highThr), .cmd(cmd), .outOfRange(outOfRange), .runNext(runNext)
  );

  wpi_control #(.CODE_W(CODE_W), .CNT_W(CNT_W), .LIN_CODES(LIN_CODES), .STEP(STEP)) ctl (
    .clk(clk), .rstN(rstN), .sampleValid(sampleValid), .irqClear(irqClear),
    .persistCode(persistCode), .outOfRange(outOfRange), .runNext(runNext),
    .cmd(cmd), .irqStatus(irqStatus)
  );

  assign irqPinN = ~(irqStatus & irqEnable);
endmodule

// File: rtl/wpi_checker.sv
module wpi_checker #(
  parameter int DATA_W = 16,
  parameter int CODE_W = 4
) (
  input logic              clk,
  input logic              rstN,
  input logic [DATA_W-1:0] sample,
  input logic              sampleValid,
  input logic [DATA_W-1:0] lowThr,
  input logic [DATA_W-1:0] highThr,
  input logic [CODE_W-1:0] persistCode,
  input logic              irqEnable,
  input logic              irqClear,
  input logic              irqStatus,
  input logic              irqPinN
);
  AST_MASKED_PIN_HIGH: assert property (@(posedge clk) disable iff (!rstN)
    !irqEnable |-> irqPinN); // R10
  AST_STATUS_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    irqStatus && !irqClear |=> irqStatus); // R7
  AST_CLEAR_DROPS: assert property (@(posedge clk) disable iff (!rstN)
    irqClear && !sampleValid |=> !irqStatus); // R7
  AST_NO_SAMPLE_NO_RISE: assert property (@(posedge clk) disable iff (!rstN)
    !irqStatus && !sampleValid |=> !irqStatus); // R6
  AST_CODE0_EVERY: assert property (@(posedge clk) disable iff (!rstN)
    sampleValid && persistCode == '0 |=> irqStatus); // R3
  AST_INSIDE_NO_RISE: assert property (@(posedge clk) disable iff (!rstN)
    sampleValid && persistCode != '0 && !irqStatus && sample >= lowThr
      && sample <= highThr |=> !irqStatus); // R1
  AST_ENABLE_SHOWS: assert property (@(posedge clk) disable iff (!rstN)
    irqStatus && irqEnable |-> !irqPinN); // R10
endmodule

bind wpi_irq wpi_checker #(.DATA_W(DATA_W), .CODE_W(CODE_W)) chk (
  .clk(clk), .rstN(rstN), .sample(sample), .sampleValid(sampleValid),
  .lowThr(lowThr), .highThr(highThr), .persistCode(persistCode),
  .irqEnable(irqEnable), .irqClear(irqClear), .irqStatus(irqStatus),
  .irqPinN(irqPinN)
);

// File: tb/wpi_irq_test.sv
module wpi_irq_test;
  logic        clk = 0;
  logic        rstN = 0;
  logic [15:0] sample = 0;
  logic        sampleValid = 0;
  logic [15:0] lowThr = 0;
  logic [15:0] highThr = 0;
  logic [3:0]  persistCode = 0;
  logic        irqEnable = 0;
  logic        irqClear = 0;
  logic        irqStatus, irqPinN;
  int compared = 0, mismatched = 0;
  bit done = 0;

  always #10 clk = ~clk;

  wpi_irq uut (
    .clk(clk), .rstN(rstN), .sample(sample), .sampleValid(sampleValid),
    .lowThr(lowThr), .highThr(highThr), .persistCode(persistCode),
    .irqEnable(irqEnable), .irqClear(irqClear), .irqStatus(irqStatus),
    .irqPinN(irqPinN)
  );

  task automatic check(input logic got, input logic exp, input string req);
    compared++;
    if (got !== exp) begin
      mismatched++;
      $display("FAIL %s: got %0b expected %0b at %0t", req, got, exp, $time);
    end
  endtask

  // called at a negedge; returns at the next negedge with the edge applied
  task automatic cyc(input logic v, input logic [15:0] s, input logic c);
    sampleValid = v; sample = s; irqClear = c;
    @(negedge clk);
    sampleValid = 0; irqClear = 0;
  endtask

  function automatic int reqOf(input int code);
    return (code <= 3) ? code : 5 * (code - 3);
  endfunction

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog: got timeout expected completion");
    finishRun();
  end

  initial begin
    repeat (3) @(negedge clk);
    check(irqStatus, 1'b0, "R11 status");
    check(irqPinN, 1'b1, "R11 pin");
    rstN = 1;
    @(negedge clk);

    // comparator sweep on small limits, single-sample code
    persistCode = 1;
    for (int l = 0; l < 5; l++)
      for (int h = 0; h < 5; h++)
        for (int s = 0; s < 6; s++) begin
          logic exp;
          lowThr = 16'(l); highThr = 16'(h);
          exp = (s < l) || (l <= h && s > h);
          cyc(1, 16'(s), 0);
          check(irqStatus, exp, (l > h) ? "R2 window" : "R1 window");
          cyc(0, 0, 1);
        end

    lowThr = 100; highThr = 200;
    // every code: run one short, then exact
    for (int code = 1; code < 16; code++) begin
      int n;
      persistCode = 4'(code);
      n = reqOf(code);
      for (int k = 1; k < n; k++) begin
        cyc(1, (k % 2) ? 16'd50 : 16'd250, 0);
        check(irqStatus, 1'b0, (code <= 3) ? "R4 early" : "R5 early");
      end
      cyc(0, 0, 0);  // idle cycle must not break the run
      cyc(1, 16'd300, 0);
      check(irqStatus, 1'b1, (code <= 3) ? "R4 reach" : "R5 reach");
      cyc(0, 0, 0);
      check(irqStatus, 1'b1, "R7 hold");
      cyc(0, 0, 1);
      check(irqStatus, 1'b0, "R7 clear");
    end

    // in-window sample breaks the run
    for (int code = 2; code < 16; code++) begin
      int n;
      persistCode = 4'(code);
      n = reqOf(code);
      for (int k = 1; k < n; k++) cyc(1, 16'd10, 0);
      cyc(1, 16'd150, 0);
      for (int k = 1; k < n; k++) cyc(1, 16'd10, 0);
      check(irqStatus, 1'b0, "R6 break");
      cyc(1, 16'd10, 0);
      check(irqStatus, 1'b1, "R6 after break");
      cyc(0, 0, 1);
    end

    // code 0 fires on in-window samples
    persistCode = 0;
    cyc(0, 0, 0);
    check(irqStatus, 1'b0, "R3 idle");
    cyc(1, 16'd150, 0);
    check(irqStatus, 1'b1, "R3 inside");
    cyc(1, 16'd150, 1);
    check(irqStatus, 1'b1, "R8 code0 with clear");
    cyc(0, 0, 1);

    // clear together with completing sample
    persistCode = 1;
    cyc(1, 16'd20, 1);
    check(irqStatus, 1'b1, "R8 set wins");
    cyc(1, 16'd150, 1);
    check(irqStatus, 1'b0, "R7 clear with inside sample");

    // clear restarts the run
    persistCode = 3;
    cyc(1, 16'd20, 0);
    cyc(1, 16'd20, 0);
    cyc(0, 0, 1);
    cyc(1, 16'd20, 0);
    check(irqStatus, 1'b0, "R9 restart 1");
    cyc(1, 16'd20, 0);
    check(irqStatus, 1'b0, "R9 restart 2");
    cyc(1, 16'd20, 0);
    check(irqStatus, 1'b1, "R9 restart 3");

    // long run past counter range keeps status
    persistCode = 15;
    cyc(0, 0, 1);
    for (int k = 0; k < 130; k++) cyc(1, 16'd20, 0);
    check(irqStatus, 1'b1, "R6 long run");

    // mask only gates the pin
    irqEnable = 0;
    #1;
    check(irqPinN, 1'b1, "R10 masked pin");
    check(irqStatus, 1'b1, "R10 masked status");
    irqEnable = 1;
    #1;
    check(irqPinN, 1'b0, "R10 enabled pin");
    cyc(0, 0, 1);
    check(irqPinN, 1'b1, "R10 pin after clear");

    finishRun();
  end
endmodule